// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block works out which column each beat of one SDRAM read or write burst uses, and on which beat the burst ends. A controller pulses `start` with the first column and the current mode settings: a length code and an ordering bit. The block then steps through the burst one beat per enabled clock edge. It drives the column together with a valid flag, and it raises a last-beat flag on the final beat of a fixed-length burst.

Fixed bursts of 2, 4 or 8 beats stay inside the aligned block that holds the start column. Linear order counts upward through that block and wraps inside it. Interleaved order XORs the beat index into the low column bits. A full-page burst runs through all 512 columns and wraps from 511 to 0. It continues until a stop request or a new start ends it.

A low clock enable freezes the whole sequence in place. The block issues no commands, keeps no bank state and does not handle data.

Top module: `burst_col_gen`

## Requirements
- R1: When `start` is sampled high with `cke` high, the next cycle shows `valid`=1 and `col` equal to the sampled `start_col`.
- R2: The length code selects the burst length: 3'b000=1, 3'b001=2, 3'b010=4, 3'b011=8 and 3'b111=full page. The reserved codes 3'b100 to 3'b110 give a single beat.
- R3: With `burst_type`=0 (linear) and a length of 2, 4 or 8, beat i carries the start column's low log2(BL) bits plus i, modulo BL. The upper column bits stay those of the start column.
- R4: With `burst_type`=1 (interleaved) and a length of 2, 4 or 8, beat i carries the start column's low log2(BL) bits XORed with i. The upper column bits stay those of the start column.
- R5: A full-page burst steps the column up by one on each beat, modulo 512, so 511 is followed by 0. It always uses linear order, whatever `burst_type` is. It never asserts `last` and runs until it is stopped or restarted.
- R6: `last` is high on exactly the final beat of a fixed-length burst. `valid` is low in the cycle after that beat, unless a new burst starts.
- R7: When `stop` is sampled high with `cke` high during a burst, `valid` is low in the next cycle. When no burst is running, `stop` has no effect.
- R8: While `cke` is sampled low, `col`, `valid` and `last` hold their values, and `start` and `stop` are ignored.
- R9: A `start` sampled during a burst abandons that burst and begins the new one. When `start` and `stop` arrive together, `start` takes priority.
- R10: After reset, `valid`=0, `last`=0 and `col`=0.
- R11: The length code and the ordering bit are captured at start. Changing them during a burst does not change its sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cke | input | 1 | Clock enable; low freezes the sequence |
| start | input | 1 | Begins a burst at `start_col` |
| start_col | input | 9 | First column of the burst |
| len_code | input | 3 | Burst length code (see R2) |
| burst_type | input | 1 | 0 = linear, 1 = interleaved |
| stop | input | 1 | Ends the running burst early |
| col | output | 9 | Column for the current beat |
| valid | output | 1 | A burst beat is being presented |
| last | output | 1 | Current beat is the final one of a fixed burst |

## Verification
The bench starts fixed bursts from columns in the middle of their aligned block. A design that carried into the upper bits, or that confused linear order with interleaved order, would therefore leave the block or produce the wrong beat order. A full-page burst is started near column 511 so that the wrap to 0 is exercised, with the ordering bit set to show that it is ignored. While a burst is frozen, `start` and `stop` pulses are applied; a design that let them through would advance, restart or end the burst. The bench also covers a restart in the middle of a burst with `stop` raised in the same cycle, mode inputs that change after the start, the reserved length codes, and a stop request when no burst is running. Each of these shows at once a wrong beat count, a missing or extra `last`, or a column that drifts.

// File: rtl/bcg_pkg.sv
// Package: shared length-code and ordering encodings for the burst
// column generator. Assumes a 3-bit length code.
package bcg_pkg;

    localparam int LEN_CODE_W = 3;

    typedef enum logic [LEN_CODE_W-1:0] {
        BL_ONE   = 3'd0,
        BL_TWO   = 3'd1,
        BL_FOUR  = 3'd2,
        BL_EIGHT = 3'd3,
        BL_PAGE  = 3'd7
    } burst_len_e;

    typedef enum logic {
        ORDER_LINEAR     = 1'b0,
        ORDER_INTERLEAVE = 1'b1
    } burst_order_e;

endpackage

// File: rtl/bcg_mode_decode.sv
// Module: bcg_mode_decode
// Turns the length code and the ordering bit into a column mask, a
// full-page flag and an effective interleave flag.
// Assumes: COL_W >= 3. The mask is a run of ones in the low bits, BL-1.
// Reserved codes act as one beat. Full page always uses linear order.
module bcg_mode_decode
    import bcg_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic [LEN_CODE_W-1:0] len_code,
    input  logic                  burst_type,
    output logic [COL_W-1:0]      mask,
    output logic                  full,
    output logic                  ilv
);

    // Purpose: map the length code to the wrap mask and the full-page flag.
    always_comb begin
        full = 1'b0;
        case (len_code)
            BL_TWO:   mask = COL_W'(1);
            BL_FOUR:  mask = COL_W'(3);
            BL_EIGHT: mask = COL_W'(7);
            BL_PAGE: begin
                mask = '1;
                full = 1'b1;
            end
            default:  mask = '0;
        endcase
    end

    // Purpose: interleaved order applies only to fixed lengths.
    always_comb begin
        ilv = (burst_type == ORDER_INTERLEAVE) && !full;
    end

endmodule

// File: rtl/bcg_beat_counter.sv
// Module: bcg_beat_counter
// Keeps the burst state: the captured start column and mode, the beat
// index and the active flag. It also decides when the burst ends.
// Assumes: everything is gated by cke. start wins over stop and over the
// end of a burst. A full-page index wraps naturally at 2**COL_W.
module bcg_beat_counter #(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cke,
    input  logic             start,
    input  logic             stop,
    input  logic [COL_W-1:0] start_col,
    input  logic [COL_W-1:0] mask_in,
    input  logic             full_in,
    input  logic             ilv_in,
    output logic [COL_W-1:0] base_q,
    output logic [COL_W-1:0] idx_q,
    output logic [COL_W-1:0] mask_q,
    output logic             full_q,
    output logic             ilv_q,
    output logic             active_q,
    output logic             last
);

    logic final_beat;

    // Purpose: flag the final beat of a fixed-length burst.
    always_comb begin
        final_beat = active_q && !full_q && (idx_q == mask_q);
        last       = final_beat;
    end

    // Purpose: capture the burst at start, then advance or end it on each enabled edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q   <= '0;
            idx_q    <= '0;
            mask_q   <= '0;
            full_q   <= 1'b0;
            ilv_q    <= 1'b0;
            active_q <= 1'b0;
        end else if (cke) begin
            if (start) begin
                base_q   <= start_col;
                idx_q    <= '0;
                mask_q   <= mask_in;
                full_q   <= full_in;
                ilv_q    <= ilv_in;
                active_q <= 1'b1;
            end else if (active_q) begin
                if (stop || final_beat) begin
                    active_q <= 1'b0;
                end else begin
                    idx_q <= idx_q + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/bcg_addr_map.sv
// Module: bcg_addr_map
// Combinational: forms the beat's column from the start column, the beat
// index, the wrap mask and the ordering.
// Assumes: the mask is contiguous from bit 0, so the low bits of the sum
// wrap inside the aligned block and the masked bits are the only ones
// that change.
module bcg_addr_map #(
    parameter int COL_W = 9
) (
    input  logic [COL_W-1:0] base,
    input  logic [COL_W-1:0] idx,
    input  logic [COL_W-1:0] mask,
    input  logic             ilv,
    output logic [COL_W-1:0] col
);

    logic [COL_W-1:0] lin_sum;

    // Purpose: linear candidate; only its masked low bits are used.
    always_comb begin
        lin_sum = base + idx;
    end

    // Purpose: choose each column bit separately, by mask and ordering.
    for (genvar b = 0; b < COL_W; b++) begin : g_bit
        always_comb begin
            if (!mask[b]) begin
                col[b] = base[b];
            end else if (ilv) begin
                col[b] = base[b] ^ idx[b];
            end else begin
                col[b] = lin_sum[b];
            end
        end
    end

endmodule

// File: rtl/burst_col_gen.sv
// Module: burst_col_gen (top)
// Produces the column sequence for one SDRAM burst: lengths of 1, 2, 4
// or 8 beats or a full page, in linear or interleaved order, with an
// early stop and a freeze while cke is low.
// Assumes: the mode inputs are only meaningful in the cycle of start.
// The outputs come from registered state through combinational mapping.
module burst_col_gen
    import bcg_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cke,
    input  logic                  start,
    input  logic [COL_W-1:0]      start_col,
    input  logic [LEN_CODE_W-1:0] len_code,
    input  logic                  burst_type,
    input  logic                  stop,
    output logic [COL_W-1:0]      col,
    output logic                  valid,
    output logic                  last
);

    logic [COL_W-1:0] dec_mask;
    logic             dec_full;
    logic             dec_ilv;
    logic [COL_W-1:0] base_q;
    logic [COL_W-1:0] idx_q;
    logic [COL_W-1:0] mask_q;
    logic             full_q;
    logic             ilv_q;
    logic             active_q;

    bcg_mode_decode #(.COL_W(COL_W)) u_decode (
        .len_code   (len_code),
        .burst_type (burst_type),
        .mask       (dec_mask),
        .full       (dec_full),
        .ilv        (dec_ilv)
    );

    bcg_beat_counter #(.COL_W(COL_W)) u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .cke       (cke),
        .start     (start),
        .stop      (stop),
        .start_col (start_col),
        .mask_in   (dec_mask),
        .full_in   (dec_full),
        .ilv_in    (dec_ilv),
        .base_q    (base_q),
        .idx_q     (idx_q),
        .mask_q    (mask_q),
        .full_q    (full_q),
        .ilv_q     (ilv_q),
        .active_q  (active_q),
        .last      (last)
    );

    bcg_addr_map #(.COL_W(COL_W)) u_map (
        .base (base_q),
        .idx  (idx_q),
        .mask (mask_q),
        .ilv  (ilv_q),
        .col  (col)
    );

    // Purpose: a beat is presented while a burst is active.
    always_comb begin
        valid = active_q;
    end

endmodule

// File: rtl/bcg_checker.sv
// Module: bcg_checker
// Temporal checks on burst_col_gen, attached by bind. It observes the top
// ports and the registered full-page flag.
module bcg_checker #(
    parameter int COL_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cke,
    input logic             start,
    input logic             stop,
    input logic [COL_W-1:0] start_col,
    input logic [COL_W-1:0] col,
    input logic             valid,
    input logic             last,
    input logic             full_q
);

    AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (start && cke) |=> (valid && col == $past(start_col)));  // R1

    AST_LAST_IMPLIES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        last |-> valid);  // R6

    AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (last && cke && !start) |=> !valid);  // R6

    AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && stop && cke && !start) |=> !valid);  // R7

    AST_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |=> ($stable(col) && $stable(valid) && $stable(last)));  // R8

    AST_PAGE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && full_q && cke && !start && !stop)
            |=> (valid && col == COL_W'($past(col) + 1'b1)));  // R5

    AST_PAGE_NO_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && full_q) |-> !last);  // R5

endmodule

bind burst_col_gen bcg_checker #(.COL_W(COL_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cke       (cke),
    .start     (start),
    .stop      (stop),
    .start_col (start_col),
    .col       (col),
    .valid     (valid),
    .last      (last),
    .full_q    (full_q)
);

// File: tb/burst_col_gen_tb.sv
`timescale 1ns/1ps
// Directed bench for burst_col_gen: one task per scenario. Inputs are
// driven and outputs sampled on the falling edge.
module burst_col_gen_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cke = 1'b1;
    logic       start = 1'b0;
    logic [8:0] start_col = '0;
    logic [2:0] len_code = '0;
    logic       burst_type = 1'b0;
    logic       stop = 1'b0;
    logic [8:0] col;
    logic       valid;
    logic       last;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    burst_col_gen u_dut (
        .clk(clk), .rst_n(rst_n), .cke(cke), .start(start),
        .start_col(start_col), .len_code(len_code), .burst_type(burst_type),
        .stop(stop), .col(col), .valid(valid), .last(last)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_col(int s, int bl, bit ilv, int i);
        int m;
        if (bl == 512) return (s + i) % 512;
        m = bl - 1;
        if (ilv) return (s & ~m & 511) | ((s ^ i) & m);
        return (s & ~m & 511) | ((s + i) & m);
    endfunction

    // Start a burst and check every beat, then the idle cycle after it.
    task automatic run_fixed(input string req, input int s, input logic [2:0] code,
                             input bit typ, input int bl);
        start_col = 9'(s); len_code = code; burst_type = typ; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < bl; i++) begin
            check(valid === 1'b1, req, "valid", int'(valid), 1);
            check(col === 9'(exp_col(s, bl, typ, i)), req, "col", int'(col), exp_col(s, bl, typ, i));
            check(last === (i == bl - 1), req, "last", int'(last), int'(i == bl - 1));
            @(negedge clk);
        end
        check(valid === 1'b0, "R6", "valid after final beat", int'(valid), 0);
    endtask

    task automatic t_reset();
        check(valid === 1'b0, "R10", "valid", int'(valid), 0);
        check(last === 1'b0, "R10", "last", int'(last), 0);
        check(col === 9'd0, "R10", "col", int'(col), 0);
    endtask

    task automatic t_lengths();
        run_fixed("R2", 300, 3'b000, 1'b0, 1);
        run_fixed("R2", 77, 3'b101, 1'b1, 1);
        run_fixed("R3", 502, 3'b010, 1'b0, 4);
        run_fixed("R3", 13, 3'b011, 1'b0, 8);
        run_fixed("R4", 13, 3'b011, 1'b1, 8);
        run_fixed("R4", 7, 3'b001, 1'b1, 2);
        run_fixed("R4", 258, 3'b010, 1'b1, 4);
    endtask

    // Full page from 509 with the ordering bit set: wrap, then stop.
    task automatic t_page_stop();
        start_col = 9'd509; len_code = 3'b111; burst_type = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 6; i++) begin
            check(valid === 1'b1, "R5", "page valid", int'(valid), 1);
            check(col === 9'(exp_col(509, 512, 1'b0, i)), "R5", "page col", int'(col), exp_col(509, 512, 1'b0, i));
            check(last === 1'b0, "R5", "page last", int'(last), 0);
            if (i == 5) stop = 1'b1;
            @(negedge clk);
        end
        stop = 1'b0;
        check(valid === 1'b0, "R7", "valid after stop", int'(valid), 0);
    endtask

    task automatic t_stop_idle();
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        check(valid === 1'b0, "R7", "stop while idle", int'(valid), 0);
        check(last === 1'b0, "R7", "last while idle", int'(last), 0);
    endtask

    // Linear 8 from 13, frozen after beat 2 with start and stop pulsed.
    task automatic t_freeze();
        start_col = 9'd13; len_code = 3'b011; burst_type = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 8; i++) begin
            check(col === 9'(exp_col(13, 8, 1'b0, i)), "R8", "col", int'(col), exp_col(13, 8, 1'b0, i));
            check(last === (i == 7), "R8", "last", int'(last), int'(i == 7));
            if (i == 2) begin
                cke = 1'b0; start = 1'b1; start_col = 9'd400; stop = 1'b1;
                for (int k = 0; k < 3; k++) begin
                    @(negedge clk);
                    check(valid === 1'b1, "R8", "frozen valid", int'(valid), 1);
                    check(col === 9'd15, "R8", "frozen col", int'(col), 15);
                end
                cke = 1'b1; start = 1'b0; stop = 1'b0;
            end
            @(negedge clk);
        end
        check(valid === 1'b0, "R8", "valid after resumed burst", int'(valid), 0);
    endtask

    // Restart in mid-burst, with stop raised in the same cycle.
    task automatic t_restart();
        start_col = 9'd0; len_code = 3'b011; burst_type = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        check(col === 9'd1, "R9", "beat 1 before restart", int'(col), 1);
        start_col = 9'd100; len_code = 3'b000; start = 1'b1; stop = 1'b1;
        @(negedge clk);
        start = 1'b0; stop = 1'b0;
        check(valid === 1'b1, "R9", "valid after restart", int'(valid), 1);
        check(col === 9'd100, "R1", "restart col", int'(col), 100);
        check(last === 1'b1, "R9", "single-beat last", int'(last), 1);
        @(negedge clk);
        check(valid === 1'b0, "R9", "idle after restart", int'(valid), 0);
    endtask

    // Mode inputs change after the start; the sequence must not change.
    task automatic t_capture();
        start_col = 9'd4; len_code = 3'b010; burst_type = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0; len_code = 3'b000; burst_type = 1'b1;
        for (int i = 0; i < 4; i++) begin
            check(col === 9'(4 + i), "R11", "col", int'(col), 4 + i);
            check(last === (i == 3), "R11", "last", int'(last), int'(i == 3));
            @(negedge clk);
        end
        check(valid === 1'b0, "R11", "valid after burst", int'(valid), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_lengths();
        t_page_stop();
        t_stop_idle();
        t_freeze();
        t_restart();
        t_capture();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule